// File: doc/BRIEF.md
# Single-Channel PCM Serial Link

This block carries one voice channel of pulse-code-modulated samples between a converter-side parallel bus and a one-wire bit stream. On the transmit side, a parallel sample word is captured once per word period. A bit selector then walks through the captured word, most significant bit first, and drives one bit per bit period onto `tx_bit`. On the receive side, the incoming `rx_bit` stream is sampled at the end of every bit period and shifted into a serial-to-parallel register. When the last bit of a word arrives, the completed word is copied into a holding register. That register drives the DAC bus unchanged for the whole of the next word period.

Both halves run from one system clock. A bit-period prescaler and a bit counter set the bit and word timing. The word period is `WORD_W * CLKS_PER_BIT` clock cycles. For an 8 kHz sample rate, the clock must run at 8000 × `WORD_W` × `CLKS_PER_BIT` Hz. When `tx_bit` is wired to `rx_bit`, each word appears on `dac_word` one word period after it was captured.

Top module: `pcm_serial_link`

## Requirements
- R1: While `rst_n` is low, `dac_word` is all ones, `tx_bit` is 1 and `word_sync` is 0, whatever `adc_word` and `rx_bit` do. All storage returns to all ones.
- R2: `word_sync` is high for exactly one clock cycle in every `WORD_W * CLKS_PER_BIT` cycles.
- R3: After a word is captured, `tx_bit` presents its bits most significant first. Each bit is held for exactly `CLKS_PER_BIT` cycles, and the last bit ends with the next `word_sync` cycle.
- R4: `adc_word` is sampled only at the clock edge that ends a `word_sync` cycle. Changes at any other time have no effect on `tx_bit`.
- R5: `dac_word` changes only at the clock edge that ends a `word_sync` cycle. At all other times it holds its value.
- R6: With `rx_bit` tied to `tx_bit`, `dac_word` holds the word captured at the previous `word_sync` throughout the word period that follows each `word_sync`.
- R7: `rx_bit` is sampled at the last cycle of each bit period. The first bit sampled in a word becomes bit `WORD_W-1` of `dac_word`, and the last becomes bit 0.
- R8: `word_sync` is high in the first cycle after reset is released. `dac_word` stays all ones until the edge that ends the second `word_sync` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock shared by transmit and receive |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_word | input | WORD_W | Parallel sample from the converter |
| tx_bit | output | 1 | Serial transmit stream, MSB first |
| word_sync | output | 1 | One-cycle strobe marking the last cycle of each word |
| rx_bit | input | 1 | Serial receive stream |
| dac_word | output | WORD_W | Held received word for the DAC |

## Verification
The bench builds the link with `WORD_W = 8` and `CLKS_PER_BIT = 2`. This exercises the widened word and a non-trivial prescaler in one run. With a 16-cycle word period, the bench can drive a full loopback sequence, mid-word glitches on the sample bus, an independent receive bit pattern and a reset in the middle of a word. Each of these spans many word boundaries, and every cycle is compared against a bench-side timing model.

// File: rtl/pcm_serial_link.sv
module pcm_serial_link #(
  parameter int WORD_W       = 4,
  parameter int CLKS_PER_BIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] adc_word,
  output logic              tx_bit,
  output logic              word_sync,
  input  logic              rx_bit,
  output logic [WORD_W-1:0] dac_word
);

  localparam int PW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam int IW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CLKS_PER_BIT - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(WORD_W - 1);

  logic [PW-1:0]     pre_q;
  logic [IW-1:0]     idx_q;
  logic [WORD_W-1:0] cap_q;
  logic [WORD_W-1:0] rx_sh_q;
  logic [WORD_W-1:0] dac_q;
  logic [WORD_W-1:0] rx_next;
  logic [IW-1:0]     sel;
  logic              bit_tick;
  logic              word_end;

  assign bit_tick  = (pre_q == PRE_LAST);
  assign word_end  = bit_tick && (idx_q == IDX_LAST);
  assign word_sync = word_end & rst_n;
  assign rx_next   = {rx_sh_q[WORD_W-2:0], rx_bit};
  assign sel       = IDX_LAST - idx_q;
  assign tx_bit    = cap_q[sel];
  assign dac_word  = dac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q   <= PRE_LAST;
      idx_q   <= IDX_LAST;
      cap_q   <= '1;
      rx_sh_q <= '1;
      dac_q   <= '1;
    end else begin
      pre_q <= bit_tick ? '0 : pre_q + 1'b1;
      if (bit_tick) begin
        idx_q   <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
        rx_sh_q <= rx_next;
      end
      if (word_end) begin
        cap_q <= adc_word;
        dac_q <= rx_next;
      end
    end
  end

  p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    word_sync |=> !word_sync);

  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(tx_bit));

  p_capture_msb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_sync |=> tx_bit == $past(adc_word[WORD_W-1]));

  p_dac_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !word_sync |=> $stable(dac_word));

  p_last_bit_lsb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    word_sync |=> dac_word[0] == $past(rx_bit));

endmodule

// File: tb/pcm_serial_link_bench.sv
`timescale 1ns/1ps
module pcm_serial_link_bench;
  localparam int W   = 8;
  localparam int DIV = 2;
  localparam int P   = W * DIV;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] adc_word = '0;
  logic         tx_bit;
  logic         word_sync;
  logic         rx_bit;
  logic         rx_drv = 1'b0;
  logic         loop_en = 1'b1;
  logic [W-1:0] dac_word;

  int total = 0;
  int bad = 0;
  int c = 0;
  int b = 0;
  bit done = 0;
  logic [W-1:0] m_cap = '1, m_sh = '1, m_dac = '1;

  always #2.5 clk = ~clk;
  assign rx_bit = loop_en ? tx_bit : rx_drv;

  pcm_serial_link #(.WORD_W(W), .CLKS_PER_BIT(DIV)) u_pcm_serial_link (
    .clk(clk), .rst_n(rst_n), .adc_word(adc_word), .tx_bit(tx_bit),
    .word_sync(word_sync), .rx_bit(rx_bit), .dac_word(dac_word));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, c, act, exp);
    end
  endtask

  // cycle-level model of the timing rules, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst_n) begin
      chk(dac_word == '1, "R1 dac", dac_word, {W{1'b1}});
      chk(tx_bit == 1'b1, "R1 tx", tx_bit, 1);
      chk(word_sync == 1'b0, "R1 sync", word_sync, 0);
      c = 0; m_cap = '1; m_sh = '1; m_dac = '1;
    end else begin
      b = (c == 0) ? W - 1 : ((c - 1) % P) / DIV;
      chk(word_sync == (c % P == 0), "R2 sync", word_sync, (c % P == 0));
      chk(tx_bit == m_cap[W-1-b], "R3 tx", tx_bit, m_cap[W-1-b]);
      chk(dac_word == m_dac, "R5 dac", dac_word, m_dac);
      if (c % DIV == 0) m_sh = {m_sh[W-2:0], rx_bit};
      if (c % P == 0) begin
        m_dac = m_sh;
        m_cap = adc_word;
      end
      c++;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic align();
    while (c % P != 0) step();
  endtask

  task automatic t_reset_state();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      adc_word = 8'h5A ^ W'(i);
      loop_en = 1'b0;
      rx_drv = i[0];
      step();
      chk(dac_word == '1, "R1 dac in reset", dac_word, {W{1'b1}});
      chk(tx_bit == 1'b1 && word_sync == 1'b0, "R1 tx/sync in reset", {tx_bit, word_sync}, 2'b10);
    end
    loop_en = 1'b1;
  endtask

  task automatic t_release();
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk(word_sync == 1'b1, "R8 first sync", word_sync, 1);
    @(posedge clk); #1;
    chk(word_sync == 1'b0, "R8 sync drops", word_sync, 0);
    for (int i = 1; i < P; i++) begin
      chk(dac_word == '1, "R8 dac ones", dac_word, {W{1'b1}});
      step();
    end
  endtask

  task automatic t_loopback();
    logic [W-1:0] prev;
    logic [W-1:0] w;
    loop_en = 1'b1;
    align();
    prev = '0;
    for (int i = 0; i < 10; i++) begin
      w = W'(8'h3C * (i + 1) ^ 8'hA5);
      adc_word = w;
      step();
      if (i > 0) chk(dac_word == prev, "R6 loopback", dac_word, prev);
      for (int k = 1; k < P; k++) step();
      prev = w;
    end
  endtask

  task automatic t_adc_glitch();
    logic [W-1:0] w;
    loop_en = 1'b1;
    align();
    w = 8'h96;
    adc_word = w;
    step();
    for (int k = 1; k < P; k++) begin
      adc_word = W'($urandom);
      step();
    end
    adc_word = 8'h00;
    step();
    chk(dac_word == w, "R4 glitches ignored", dac_word, w);
  endtask

  task automatic t_rx_stream();
    logic [W-1:0] pat [2];
    pat[0] = 8'hB1;
    pat[1] = 8'h4E;
    loop_en = 1'b0;
    align();
    step();
    for (int n = 0; n < 2; n++) begin
      for (int i = 0; i < W; i++) begin
        rx_drv = pat[n][W-1-i];
        step();
        rx_drv = ~pat[n][W-1-i];
        if (DIV > 1) begin
          rx_drv = pat[n][W-1-i];
          step();
        end
      end
      chk(dac_word == pat[n], "R7 rx order", dac_word, pat[n]);
    end
    loop_en = 1'b1;
  endtask

  task automatic t_midreset();
    align();
    for (int k = 0; k < 5; k++) step();
    rst_n = 1'b0;
    #1;
    chk(dac_word == '1 && tx_bit == 1'b1 && word_sync == 1'b0, "R1 async reset",
        {dac_word, tx_bit, word_sync}, {{W{1'b1}}, 2'b10});
    step();
    step();
    t_release();
    t_loopback();
  endtask

  initial begin
    t_reset_state();
    t_release();
    t_loopback();
    t_adc_glitch();
    t_rx_stream();
    t_midreset();
    step();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule